// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and a cartridge that holds a large ROM and, as an option, a banked external RAM. It keeps no data of its own. A CPU write below 0x8000 does not reach any memory. Instead it updates one of four control registers, chosen by the top three address bits. These registers are a RAM enable flag, a 5-bit ROM bank, a 2-bit auxiliary bank and a one-bit banking mode.

CPU reads below 0x4000 go straight to the start of ROM. CPU reads in 0x4000-0x7FFF go to the selected switchable ROM bank. Accesses in 0xA000-0xBFFF go to external RAM when it is enabled. The 2-bit auxiliary bank has two uses, and the mode bit picks one. With mode 0 it extends the ROM bank upward and external RAM is pinned to bank 0. With mode 1 it selects the external RAM bank and the upper ROM bits are forced to zero.

The physical addresses, the read strobes and the write strobe are registered. They come out one clock after the CPU access. The byte returned to the CPU is also registered and follows one clock later. The ROM and RAM arrays sit outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is high and after it is released, every control register reads as zero: RAM disabled, ROM bank 0, auxiliary bank 0, mode 0. `rom_rd_o`, `ram_rd_o` and `ram_wr_o` are low, and `cpu_rdata_o` is 0x00.
- R2: A CPU write to 0x0000-0x1FFF enables external RAM when data bits [3:0] equal 0xA. Any other low nibble disables it, and the upper nibble is ignored.
- R3: A CPU write to 0x2000-0x3FFF loads data bits [4:0] into the ROM bank register. Bits [7:5] are dropped.
- R4: A CPU write anywhere in 0x0000-0x7FFF produces no ROM strobe and no RAM write strobe in the following cycle.
- R5: When the ROM bank register holds zero, reads in 0x4000-0x7FFF use bank 1. `rom_addr_o[18:14]` is then 1.
- R6: A CPU write to 0x4000-0x5FFF loads data bits [1:0] into the auxiliary bank. With mode 0, a read in 0x4000-0x7FFF drives `rom_addr_o` = {auxiliary bank[1:0], ROM bank[4:0], cpu_addr[13:0]}.
- R7: A CPU write to 0x6000-0x7FFF loads data bit 0 into the mode bit. With mode 1, `rom_addr_o[20:19]` is 0 for switchable-window reads, and the external RAM bank equals the auxiliary bank.
- R8: A read in 0x0000-0x3FFF drives `rom_addr_o` = {7'b0, cpu_addr[13:0]}, whatever the bank, auxiliary and mode registers hold.
- R9: With RAM enabled, an access in 0xA000-0xBFFF drives `ram_addr_o` = {mode ? auxiliary bank : 2'b00, cpu_addr[12:0]}. A write carries `cpu_wdata_i` on `ram_wdata_o` and pulses `ram_wr_o`. A read pulses `ram_rd_o`.
- R10: With RAM disabled, or with the RAM-present parameter at 0, accesses in 0xA000-0xBFFF raise no RAM strobe, and reads there return 0x00.
- R11: Strobes and addresses appear one clock edge after the access is sampled. `cpu_rdata_o` updates one edge after that and holds between reads. Reads in 0x8000-0x9FFF and 0xC000-0xFFFF return 0x00 and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | CPU read request, one cycle per access |
| cpu_wr_i | input | 1 | CPU write request, one cycle per access |
| cpu_rdata_o | output | 8 | Registered read data returned to the CPU |
| rom_addr_o | output | 21 | Physical ROM address |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_rdata_i | input | 8 | ROM data for `rom_addr_o` |
| ram_addr_o | output | 15 | Physical external RAM address |
| ram_rd_o | output | 1 | External RAM read strobe |
| ram_wr_o | output | 1 | External RAM write strobe |
| ram_wdata_o | output | 8 | External RAM write data |
| ram_rdata_i | input | 8 | External RAM data for `ram_addr_o` |

## Verification
The strobes, the physical addresses and the RAM write data are due one rising edge after the edge that samples the CPU access. The returned byte is due one edge after that. The reference model in the bench runs on the rising edge and keeps this two-stage timing with a pending-read slot. Outputs are compared at the following falling edge, so each one is checked exactly in the cycle it becomes valid. A second instance built without RAM gets the same stimulus, so the gating of the RAM strobes and the 0x00 read return are checked cycle by cycle as well.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // Which 8 KiB slice of the CPU space an access falls in (top three address bits).
  typedef enum logic [2:0] {
    AREA_CTL_ENABLE = 3'd0,
    AREA_CTL_BANK   = 3'd1,
    AREA_CTL_SECOND = 3'd2,
    AREA_CTL_MODE   = 3'd3,
    AREA_VIDEO      = 3'd4,
    AREA_EXTRAM     = 3'd5,
    AREA_WORK       = 3'd6
  } area_e;

  // Source of the byte returned to the CPU in the second pipeline stage.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_ZERO = 2'd3
  } rd_src_e;

  localparam logic [3:0] ENABLE_KEY = 4'hA;

  function automatic area_e decode_area(input logic [2:0] top);
    case (top)
      3'd0:    return AREA_CTL_ENABLE;
      3'd1:    return AREA_CTL_BANK;
      3'd2:    return AREA_CTL_SECOND;
      3'd3:    return AREA_CTL_MODE;
      3'd4:    return AREA_VIDEO;
      3'd5:    return AREA_EXTRAM;
      default: return AREA_WORK;
    endcase
  endfunction

endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
  import cart_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 5,
  parameter int SEC_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  area_e                 area_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  ram_en_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [SEC_W-1:0]      sec_bank_o,
  output logic                  mode_o
);

  // Bits above the widest field are never stored.
  logic unused_hi_bits;
  assign unused_hi_bits = &{1'b0, wdata_i[DATA_W-1:ROM_BANK_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en_o   <= 1'b0;
      rom_bank_o <= '0;
      sec_bank_o <= '0;
      mode_o     <= 1'b0;
    end else if (wr_i) begin
      case (area_i)
        AREA_CTL_ENABLE: ram_en_o   <= (wdata_i[3:0] == ENABLE_KEY);
        AREA_CTL_BANK:   rom_bank_o <= wdata_i[ROM_BANK_W-1:0];
        AREA_CTL_SECOND: sec_bank_o <= wdata_i[SEC_W-1:0];
        AREA_CTL_MODE:   mode_o     <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // R2
  ram_enable_key_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_i && area_i == AREA_CTL_ENABLE)
      |-> (ram_en_o == ($past(wdata_i[3:0]) == ENABLE_KEY)));

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_i && area_i == AREA_CTL_MODE) |-> (mode_o == $past(wdata_i[0])));

  // R1
  regs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ram_en_o && rom_bank_o == '0 && sec_bank_o == '0 && !mode_o));

endmodule

// File: rtl/cart_rom_map.sv
module cart_rom_map #(
  parameter int ROM_BANK_W = 5,
  parameter int SEC_W      = 2,
  parameter int ROM_OFS_W  = 14,
  parameter int ROM_ADDR_W = SEC_W + ROM_BANK_W + ROM_OFS_W
) (
  input  logic                  banked_i,
  input  logic [ROM_OFS_W-1:0]  ofs_i,
  input  logic [ROM_BANK_W-1:0] bank_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic                  mode_i,
  output logic [ROM_ADDR_W-1:0] rom_addr_o
);

  localparam int HI_W = SEC_W + ROM_BANK_W;
  localparam logic [ROM_BANK_W-1:0] BANK_FLOOR = {{(ROM_BANK_W-1){1'b0}}, 1'b1};

  logic [ROM_BANK_W-1:0] bank_eff;
  logic [SEC_W-1:0]      upper;

  always_comb begin
    bank_eff = (bank_i == '0) ? BANK_FLOOR : bank_i;
    upper    = mode_i ? '0 : sec_i;
    if (banked_i) rom_addr_o = {upper, bank_eff, ofs_i};
    else          rom_addr_o = {{HI_W{1'b0}}, ofs_i};
  end

endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map #(
  parameter int HAS_RAM    = 1,
  parameter int SEC_W      = 2,
  parameter int RAM_OFS_W  = 13,
  parameter int RAM_ADDR_W = SEC_W + RAM_OFS_W
) (
  input  logic                  sel_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic                  ram_en_i,
  input  logic                  mode_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [RAM_OFS_W-1:0]  ofs_i,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_rd_o,
  output logic                  ram_wr_o,
  output logic                  ram_ok_o
);

  generate
    if (HAS_RAM != 0) begin : g_ram
      assign ram_ok_o = ram_en_i;
    end else begin : g_noram
      logic unused_en;
      assign unused_en = ram_en_i;
      assign ram_ok_o  = 1'b0;
    end
  endgenerate

  assign ram_addr_o = {(mode_i ? sec_i : {SEC_W{1'b0}}), ofs_i};
  assign ram_rd_o   = sel_i & rd_i & ram_ok_o;
  assign ram_wr_o   = sel_i & wr_i & ram_ok_o;

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter int  ROM_BANK_W = 5,
  parameter int  SEC_W      = 2,
  parameter int  ROM_OFS_W  = 14,
  parameter int  HAS_RAM    = 1,
  localparam int ADDR_W     = ROM_OFS_W + 2,
  localparam int RAM_OFS_W  = ROM_OFS_W - 1,
  localparam int ROM_ADDR_W = SEC_W + ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_ADDR_W = SEC_W + RAM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_wdata_i,
  input  logic                  cpu_rd_i,
  input  logic                  cpu_wr_i,
  output logic [DATA_W-1:0]     cpu_rdata_o,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic                  rom_rd_o,
  input  logic [DATA_W-1:0]     rom_rdata_i,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_rd_o,
  output logic                  ram_wr_o,
  output logic [DATA_W-1:0]     ram_wdata_o,
  input  logic [DATA_W-1:0]     ram_rdata_i
);

  // ---------------- stage 0: decode ----------------
  area_e area;
  logic  rd_go, is_rom, banked;

  assign area   = decode_area(cpu_addr_i[ADDR_W-1 -: 3]);
  assign rd_go  = cpu_rd_i & ~cpu_wr_i;
  assign is_rom = ~cpu_addr_i[ADDR_W-1];
  assign banked = cpu_addr_i[ROM_OFS_W];

  logic                  ram_en, mode;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [SEC_W-1:0]      sec_bank;

  cart_ctrl_regs #(
    .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .SEC_W(SEC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(cpu_wr_i), .area_i(area), .wdata_i(cpu_wdata_i),
    .ram_en_o(ram_en), .rom_bank_o(rom_bank), .sec_bank_o(sec_bank), .mode_o(mode)
  );

  logic [ROM_ADDR_W-1:0] rom_addr_c;

  cart_rom_map #(
    .ROM_BANK_W(ROM_BANK_W), .SEC_W(SEC_W), .ROM_OFS_W(ROM_OFS_W), .ROM_ADDR_W(ROM_ADDR_W)
  ) u_rom_map (
    .banked_i(banked), .ofs_i(cpu_addr_i[ROM_OFS_W-1:0]), .bank_i(rom_bank),
    .sec_i(sec_bank), .mode_i(mode), .rom_addr_o(rom_addr_c)
  );

  logic [RAM_ADDR_W-1:0] ram_addr_c;
  logic                  ram_rd_c, ram_wr_c, ram_ok;

  cart_ram_map #(
    .HAS_RAM(HAS_RAM), .SEC_W(SEC_W), .RAM_OFS_W(RAM_OFS_W), .RAM_ADDR_W(RAM_ADDR_W)
  ) u_ram_map (
    .sel_i(area == AREA_EXTRAM), .rd_i(rd_go), .wr_i(cpu_wr_i), .ram_en_i(ram_en),
    .mode_i(mode), .sec_i(sec_bank), .ofs_i(cpu_addr_i[RAM_OFS_W-1:0]),
    .ram_addr_o(ram_addr_c), .ram_rd_o(ram_rd_c), .ram_wr_o(ram_wr_c), .ram_ok_o(ram_ok)
  );

  logic unused_ok;
  assign unused_ok = ram_ok;

  rd_src_e src_c;
  always_comb begin
    if (!rd_go)        src_c = SRC_HOLD;
    else if (is_rom)   src_c = SRC_ROM;
    else if (ram_rd_c) src_c = SRC_RAM;
    else               src_c = SRC_ZERO;
  end

  // ---------------- stage 1: physical access ----------------
  rd_src_e src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd_o    <= 1'b0;
      rom_addr_o  <= '0;
      ram_rd_o    <= 1'b0;
      ram_wr_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
      src_q       <= SRC_HOLD;
    end else begin
      rom_rd_o    <= rd_go & is_rom;
      rom_addr_o  <= rom_addr_c;
      ram_rd_o    <= ram_rd_c;
      ram_wr_o    <= ram_wr_c;
      ram_addr_o  <= ram_addr_c;
      ram_wdata_o <= cpu_wdata_i;
      src_q       <= src_c;
    end
  end

  // ---------------- stage 2: return data ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata_o <= '0;
    end else begin
      case (src_q)
        SRC_ROM:  cpu_rdata_o <= rom_rdata_i;
        SRC_RAM:  cpu_rdata_o <= ram_rdata_i;
        SRC_ZERO: cpu_rdata_o <= '0;
        default:  ;
      endcase
    end
  end

  // R4
  ctl_write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cpu_wr_i && !cpu_addr_i[ADDR_W-1]) |-> (!rom_rd_o && !ram_wr_o));

  // R10
  ram_strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_o || ram_wr_o) |-> ($past(ram_en) && HAS_RAM != 0));

  // R5
  bank_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd_o && $past(cpu_addr_i[ROM_OFS_W])) |-> (rom_addr_o[ROM_OFS_W +: ROM_BANK_W] != '0));

  // R7
  mode_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd_o && $past(mode)) |-> (rom_addr_o[ROM_ADDR_W-1 -: SEC_W] == '0));

  // R11
  rom_strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rom_rd_o |-> ($past(cpu_rd_i) && !$past(cpu_addr_i[ADDR_W-1])));

  // R11
  zero_return_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && src_q == SRC_ZERO) |-> (cpu_rdata_o == '0));

endmodule

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;

  logic [7:0]  cpu_rdata, rom_rdata, ram_wdata, ram_rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_rd, ram_rd, ram_wr;

  logic [7:0]  nr_cpu_rdata, nr_ram_wdata, nr_rom_rdata;
  logic [20:0] nr_rom_addr;
  logic [14:0] nr_ram_addr;
  logic        nr_rom_rd, nr_ram_rd, nr_ram_wr;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int a);
    logic [20:0] x;
    x = a[20:0];
    return x[7:0] ^ {x[20:14], 1'b0} ^ {2'b00, x[13:8]};
  endfunction

  // external memories
  logic [7:0] dram [int];
  assign rom_rdata    = rom_byte(int'(rom_addr));
  assign nr_rom_rdata = rom_byte(int'(nr_rom_addr));
  assign ram_rdata    = dram.exists(int'(ram_addr)) ? dram[int'(ram_addr)] : 8'hEE;
  always @(posedge clk) if (ram_wr) dram[int'(ram_addr)] = ram_wdata;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .cpu_rdata_o(cpu_rdata),
    .rom_addr_o(rom_addr), .rom_rd_o(rom_rd), .rom_rdata_i(rom_rdata),
    .ram_addr_o(ram_addr), .ram_rd_o(ram_rd), .ram_wr_o(ram_wr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  cart_bank_ctrl #(.HAS_RAM(0)) u_noram (
    .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .cpu_rdata_o(nr_cpu_rdata),
    .rom_addr_o(nr_rom_addr), .rom_rd_o(nr_rom_rd), .rom_rdata_i(nr_rom_rdata),
    .ram_addr_o(nr_ram_addr), .ram_rd_o(nr_ram_rd), .ram_wr_o(nr_ram_wr),
    .ram_wdata_o(nr_ram_wdata), .ram_rdata_i(8'h5A)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    m_en, m_bank, m_sec, m_mode;
  int    e_rom_rd, e_rom_addr, e_ram_rd, e_ram_wr, e_ram_addr, e_ram_wdata;
  int    e_rdata, e_rdata_nr;
  int    p_vld, p_val, p_val_nr;
  string tag1 = "R1", tag2 = "R1", p_tag = "R1";
  logic [7:0] mram [int];

  always @(posedge clk) begin
    int a, ra, b;
    if (rst) begin
      m_en = 0; m_bank = 0; m_sec = 0; m_mode = 0;
      e_rom_rd = 0; e_ram_rd = 0; e_ram_wr = 0; e_rom_addr = 0;
      e_ram_addr = 0; e_ram_wdata = 0; e_rdata = 0; e_rdata_nr = 0;
      p_vld = 0; tag1 = "R1"; tag2 = "R1";
    end else begin
      if (p_vld != 0) begin e_rdata = p_val; e_rdata_nr = p_val_nr; tag2 = p_tag; end
      p_vld = 0; e_rom_rd = 0; e_ram_rd = 0; e_ram_wr = 0; tag1 = "R11";
      a  = int'(cpu_addr);
      ra = ((m_mode != 0 ? m_sec : 0) << 13) | (a & 'h1FFF);
      if (cpu_wr) begin
        if (a < 'h8000) begin
          tag1 = "R4";
          case (a >> 13)
            0: m_en   = ((int'(cpu_wdata) & 15) == 10) ? 1 : 0;
            1: m_bank = int'(cpu_wdata) & 31;
            2: m_sec  = int'(cpu_wdata) & 3;
            default: m_mode = int'(cpu_wdata) & 1;
          endcase
        end else if (a >= 'hA000 && a < 'hC000) begin
          if (m_en != 0) begin
            e_ram_wr = 1; e_ram_addr = ra; e_ram_wdata = int'(cpu_wdata);
            mram[ra] = cpu_wdata; tag1 = "R9";
          end else tag1 = "R10";
        end
      end else if (cpu_rd) begin
        p_vld = 1;
        if (a < 'h4000) begin
          e_rom_rd = 1; e_rom_addr = a; tag1 = "R8";
          p_val = int'(rom_byte(a)); p_val_nr = p_val;
        end else if (a < 'h8000) begin
          b = (m_bank == 0) ? 1 : m_bank;
          e_rom_rd = 1;
          e_rom_addr = ((m_mode != 0 ? 0 : m_sec) << 19) | (b << 14) | (a - 'h4000);
          tag1 = (m_bank == 0) ? "R5" : ((m_mode != 0) ? "R7" : "R6");
          p_val = int'(rom_byte(e_rom_addr)); p_val_nr = p_val;
        end else if (a >= 'hA000 && a < 'hC000) begin
          p_val_nr = 0;
          if (m_en != 0) begin
            e_ram_rd = 1; e_ram_addr = ra; tag1 = "R9";
            p_val = mram.exists(ra) ? int'(mram[ra]) : 'hEE;
          end else begin
            p_val = 0; tag1 = "R10";
          end
        end else begin
          p_val = 0; p_val_nr = 0; tag1 = "R11";
        end
        p_tag = tag1;
      end
    end
  end

  // ---------------- per-cycle comparison, away from the rising edge ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag1, "rom_rd", int'(rom_rd), e_rom_rd);
      chk(tag1, "ram_rd", int'(ram_rd), e_ram_rd);
      chk(tag1, "ram_wr", int'(ram_wr), e_ram_wr);
      if (e_rom_rd != 0) chk(tag1, "rom_addr", int'(rom_addr), e_rom_addr);
      if (e_ram_rd != 0 || e_ram_wr != 0) chk(tag1, "ram_addr", int'(ram_addr), e_ram_addr);
      if (e_ram_wr != 0) chk(tag1, "ram_wdata", int'(ram_wdata), e_ram_wdata);
      chk(tag2, "cpu_rdata", int'(cpu_rdata), e_rdata);
      chk("R10", "noram ram_rd", int'(nr_ram_rd), 0);
      chk("R10", "noram ram_wr", int'(nr_ram_wr), 0);
      chk(tag2, "noram cpu_rdata", int'(nr_cpu_rdata), e_rdata_nr);
    end
  end

  // one access, returns at the falling edge where its strobes are visible
  task automatic acc(input bit w, input int a, input int d);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wdata = d[7:0]; cpu_wr = w; cpu_rd = !w;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rom_rd after reset", int'(rom_rd), 0);
    chk("R1", "ram_rd after reset", int'(ram_rd), 0);
    chk("R1", "ram_wr after reset", int'(ram_wr), 0);
    chk("R1", "cpu_rdata after reset", int'(cpu_rdata), 0);
    acc(1'b0, 'hA004, 0);
    chk("R1", "ram disabled after reset", int'(ram_rd), 0);

    acc(1'b0, 'h4000, 0);                       // R5: bank 0 -> 1
    chk("R5", "bank floor addr", int'(rom_addr), 'h4000);
    acc(1'b0, 'h0123, 0);                       // R8
    acc(1'b1, 'h2100, 'hE3);                    // R3: low five bits only
    acc(1'b0, 'h4123, 0);
    chk("R3", "rom bank field", int'(rom_addr), (3 << 14) | 'h123);
    acc(1'b1, 'h4000, 'h06);                    // R6: aux = 2
    acc(1'b0, 'h7FFF, 0);
    chk("R6", "aux extends rom", int'(rom_addr), (2 << 19) | (3 << 14) | 'h3FFF);
    acc(1'b0, 'h1FFF, 0);                       // R8 ignores banks
    acc(1'b0, 'hA010, 0);                       // R10 disabled read
    acc(1'b1, 'hA010, 'h33);                    // R10 disabled write
    acc(1'b1, 'h0000, 'h3A);                    // R2 enable key
    acc(1'b0, 'hA000, 0);
    chk("R2", "ram enabled by nibble A", int'(ram_rd), 1);
    acc(1'b1, 'hA005, 'h77);                    // R9 mode 0 -> bank 0
    acc(1'b1, 'h6000, 'hFF);                    // R7 mode 1
    acc(1'b1, 'hB005, 'h99);
    acc(1'b0, 'hA005, 0);
    acc(1'b0, 'hB005, 0);
    acc(1'b0, 'h5555, 0);                       // R7 upper bits zero
    acc(1'b1, 'h7000, 'h10);                    // mode back to 0
    acc(1'b0, 'hA005, 0);
    acc(1'b1, 'h3000, 'h20);                    // R5 low bits zero
    acc(1'b0, 'h4001, 0);
    acc(1'b1, 'h1000, 'hAB);                    // R2 other nibble disables
    acc(1'b0, 'hA005, 0);
    chk("R2", "ram disabled by other nibble", int'(ram_rd), 0);
    acc(1'b0, 'h8000, 0);                       // R11 unmapped
    acc(1'b0, 'hC000, 0);
    repeat (3) @(negedge clk);

    // back-to-back mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      @(negedge clk);
      k = $urandom_range(0, 9);
      cpu_wr = 1'b0; cpu_rd = 1'b0;
      case (k)
        0, 1: begin
          cpu_wr = 1'b1; cpu_addr = 16'($urandom_range(0, 'h7FFF));
          cpu_wdata = ($urandom_range(0, 1) != 0) ? 8'h0A : 8'($urandom_range(0, 255));
        end
        2, 3: begin cpu_wr = 1'b1; cpu_addr = 16'($urandom_range('hA000, 'hBFFF));
                    cpu_wdata = 8'($urandom_range(0, 255)); end
        4, 5: begin cpu_rd = 1'b1; cpu_addr = 16'($urandom_range('hA000, 'hBFFF)); end
        6, 7: begin cpu_rd = 1'b1; cpu_addr = 16'($urandom_range(0, 'h7FFF)); end
        8:    begin cpu_rd = 1'b1; cpu_addr = 16'($urandom_range('h8000, 'hFFFF)); end
        default: ;
      endcase
    end
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #500us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

endmodule